// File: doc/BRIEF.md
# Dual-Channel Reset Supervisor with Power-Fail Flag

This block turns three comparator flags and a push-button input into two independent active-low reset outputs and one power-fail flag. The supply channel watches a supply-good flag and the sense channel watches a sense-good flag. Both channels also obey a shared manual-reset input that is active low. Each channel holds its reset asserted while its own condition is bad. It releases only after its own parameterised number of clock cycles of continuous good condition. A nominal 130 ms maps to 26,000,000 cycles at 200 MHz.

The power-fail flag is a third comparator result. It passes to its own output after the input synchroniser and goes through no other logic. It is not tied to either reset channel. All four asynchronous inputs pass through two-flop synchronisers before any logic uses them. The analog comparators, thresholds and output drivers sit outside this block. All pins are plain control and status signals, so there is no valid/ready handshake.

Top module: `dual_rail_supervisor`

## Requirements
- R1: `supply_rst_n_o` depends only on `supply_ok_i` and `man_rst_n_i`; changing `sense_ok_i` or `pwr_ok_i` leaves it unchanged.
- R2: `sense_rst_n_o` depends only on `sense_ok_i` and `man_rst_n_i`; changing `supply_ok_i` or `pwr_ok_i` leaves it unchanged.
- R3: While `man_rst_n_i` is 0, both reset outputs are 0 whatever the other inputs are.
- R4: `supply_rst_n_o` rises exactly SUP_DELAY+2 clock edges after its inputs (`man_rst_n_i`=1 and `supply_ok_i`=1) become good. Two of those edges are synchroniser latency and SUP_DELAY are the release count.
- R5: `sense_rst_n_o` rises exactly SNS_DELAY+2 clock edges after its inputs become good. This count does not depend on the supply channel's delay.
- R6: If a channel's fault returns before its delay expires, even for one sampled cycle, that channel's count restarts from zero when the condition becomes good again.
- R7: `pwr_good_o` equals `pwr_ok_i` as sampled two clock edges earlier: 1 when the flag is true and 0 when it is false, with no further delay.
- R8: `pwr_ok_i` has no effect on either reset output, and `man_rst_n_i` has no effect on `pwr_good_o`.
- R9: While `rst_n` is 0, both reset outputs and `pwr_good_o` are 0. After `rst_n` rises, each channel starts a full release count, and `pwr_good_o` follows the synchronised flag.
- R10: A fault at a channel's inputs drives that channel's reset output to 0 on the third clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| man_rst_n_i | input | 1 | Manual reset, active low, shared by both channels |
| supply_ok_i | input | 1 | Supply comparator flag, 1 = supply above threshold |
| sense_ok_i | input | 1 | Sense comparator flag, 1 = sensed voltage above threshold |
| pwr_ok_i | input | 1 | Power-fail comparator flag, 1 = monitored voltage good |
| supply_rst_n_o | output | 1 | Supply-channel reset, active low |
| sense_rst_n_o | output | 1 | Sense-channel reset, active low |
| pwr_good_o | output | 1 | Synchronised power-fail flag, 1 = good |

## Verification
The bench removes a fault from one channel while the other channel stays good or bad. A design that cross-coupled the channels would glitch or delay the wrong output in the few cycles after each change. Release edges are sampled one cycle before and at the expected edge, for two different delay values. This catches an off-by-one counter or a single delay shared by both channels. A one-cycle fault pulse during a count checks that the count restarts; a design that only paused or ignored the pulse would release early. The power-fail flag is toggled while both resets sit in every state, and the manual reset is toggled while the flag is steady. Any leak between the two paths therefore shows up at the ports.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;
  localparam int unsigned NUM_IN = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef struct packed {
    logic pwr;
    logic sense;
    logic supply;
    logic man_n;
  } sup_flags_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/release_timer.sv
module release_timer #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_i,
  output logic rst_n_o
);
  localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!good_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_n_o = rel_q;
endmodule

// File: rtl/dual_rail_supervisor.sv
module dual_rail_supervisor
  import supervisor_pkg::*;
#(
  parameter int unsigned SUP_DELAY = 26000000,
  parameter int unsigned SNS_DELAY = 26000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic man_rst_n_i,
  input  logic supply_ok_i,
  input  logic sense_ok_i,
  input  logic pwr_ok_i,
  output logic supply_rst_n_o,
  output logic sense_rst_n_o,
  output logic pwr_good_o
);
  localparam int unsigned NUM_CH = 2;

  sup_flags_t raw_flags, syn_flags;
  logic [NUM_CH-1:0] ch_good, ch_rel;

  assign raw_flags = '{pwr: pwr_ok_i, sense: sense_ok_i,
                       supply: supply_ok_i, man_n: man_rst_n_i};

  flag_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i(raw_flags), .sync_o(syn_flags)
  );

  assign ch_good[0] = syn_flags.man_n & syn_flags.supply;
  assign ch_good[1] = syn_flags.man_n & syn_flags.sense;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    localparam int unsigned DLY = (g == 0) ? SUP_DELAY : SNS_DELAY;
    release_timer #(.DELAY(DLY)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .good_i(ch_good[g]), .rst_n_o(ch_rel[g])
    );
  end

  assign supply_rst_n_o = ch_rel[0];
  assign sense_rst_n_o  = ch_rel[1];
  assign pwr_good_o     = syn_flags.pwr;
endmodule

// File: rtl/supervisor_props.sv
module supervisor_props #(
  parameter int unsigned SUP_DELAY = 16,
  parameter int unsigned SNS_DELAY = 16
) (
  input logic clk,
  input logic rst_n,
  input logic man_rst_n_i,
  input logic supply_ok_i,
  input logic sense_ok_i,
  input logic pwr_ok_i,
  input logic supply_rst_n_o,
  input logic sense_rst_n_o,
  input logic pwr_good_o
);
  localparam int unsigned SW = $clog2(SUP_DELAY + 1) + 1;
  localparam int unsigned NW = $clog2(SNS_DELAY + 1) + 1;

  logic [1:0]    age_q;
  logic [SW-1:0] sup_run_q;
  logic [NW-1:0] sns_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q     <= '0;
      sup_run_q <= '0;
      sns_run_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (!(man_rst_n_i && supply_ok_i)) sup_run_q <= '0;
      else if (sup_run_q < SW'(SUP_DELAY)) sup_run_q <= sup_run_q + 1'b1;
      if (!(man_rst_n_i && sense_ok_i)) sns_run_q <= '0;
      else if (sns_run_q < NW'(SNS_DELAY)) sns_run_q <= sns_run_q + 1'b1;
    end
  end

  assert_pf_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (pwr_good_o == $past(pwr_ok_i, 2)));

  assert_manual_forces_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!man_rst_n_i, 3) |-> (!supply_rst_n_o && !sense_rst_n_o));

  assert_supply_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!supply_ok_i, 3) |-> !supply_rst_n_o);

  assert_sense_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sense_ok_i, 3) |-> !sense_rst_n_o);

  assert_supply_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_rst_n_o) |-> ($past(sup_run_q, 2) >= SW'(SUP_DELAY)));

  assert_sense_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sense_rst_n_o) |-> ($past(sns_run_q, 2) >= NW'(SNS_DELAY)));
endmodule

bind dual_rail_supervisor supervisor_props #(
  .SUP_DELAY(SUP_DELAY), .SNS_DELAY(SNS_DELAY)
) u_props (
  .clk(clk), .rst_n(rst_n), .man_rst_n_i(man_rst_n_i),
  .supply_ok_i(supply_ok_i), .sense_ok_i(sense_ok_i), .pwr_ok_i(pwr_ok_i),
  .supply_rst_n_o(supply_rst_n_o), .sense_rst_n_o(sense_rst_n_o),
  .pwr_good_o(pwr_good_o)
);

// File: tb/test_dual_rail_supervisor.sv
`timescale 1ns/1ps
module test_dual_rail_supervisor;
  localparam int unsigned SUP_D = 8;
  localparam int unsigned SNS_D = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic man_n = 1'b1, sup_ok = 1'b1, sns_ok = 1'b1, pf_ok = 1'b1;
  logic sup_rst_n, sns_rst_n, pf_good;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  dual_rail_supervisor #(.SUP_DELAY(SUP_D), .SNS_DELAY(SNS_D)) i_dual_rail_supervisor (
    .clk(clk), .rst_n(rst_n), .man_rst_n_i(man_n),
    .supply_ok_i(sup_ok), .sense_ok_i(sns_ok), .pwr_ok_i(pf_ok),
    .supply_rst_n_o(sup_rst_n), .sense_rst_n_o(sns_rst_n), .pwr_good_o(pf_good)
  );

  // {man_n, sup, sns, pf, early sup/sns/pf, late sup/sns/pf}
  localparam logic [9:0] VEC [8] = '{
    10'b1011_011_011, 10'b1100_000_100, 10'b1001_001_001, 10'b1110_000_110,
    10'b1111_111_111, 10'b0111_001_001, 10'b0000_000_000, 10'b1111_001_111
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    check(sup_rst_n, 1'b0, "R9 supply in reset");
    check(sns_rst_n, 1'b0, "R9 sense in reset");
    check(pf_good,   1'b0, "R9 pwr in reset");
    rst_n = 1'b1;
    step(2);
    check(pf_good, 1'b1, "R9 pwr follows synced flag");
    step(SUP_D - 1);
    check(sup_rst_n, 1'b0, "R9 supply full count after reset");
    step(1);
    check(sup_rst_n, 1'b1, "R9 supply released after reset");
    step(SNS_D + 4);

    // table walk: R1 R2 R3 R8
    for (int v = 0; v < 8; v++) begin
      logic [9:0] e;
      e = VEC[v];
      {man_n, sup_ok, sns_ok, pf_ok} = e[9:6];
      step(4);
      check(sup_rst_n, e[5], $sformatf("R1/R3 vec %0d early supply", v));
      check(sns_rst_n, e[4], $sformatf("R2/R3 vec %0d early sense", v));
      check(pf_good,   e[3], $sformatf("R8 vec %0d early pwr", v));
      step(20);
      check(sup_rst_n, e[2], $sformatf("R1/R3 vec %0d late supply", v));
      check(sns_rst_n, e[1], $sformatf("R2/R3 vec %0d late sense", v));
      check(pf_good,   e[0], $sformatf("R8 vec %0d late pwr", v));
    end

    // R10: fault latency of three edges
    man_n = 1'b0;
    step(2);
    check(sup_rst_n, 1'b1, "R10 supply before third edge");
    step(1);
    check(sup_rst_n, 1'b0, "R10 supply at third edge");
    check(sns_rst_n, 0, "R10 sense at third edge");
    step(3);

    // R4 / R5: exact release edges per channel
    man_n = 1'b1;
    step(SUP_D + 1);
    check(sup_rst_n, 1'b0, "R4 supply one edge early");
    step(1);
    check(sup_rst_n, 1'b1, "R4 supply release edge");
    step(SNS_D - SUP_D - 1);
    check(sns_rst_n, 1'b0, "R5 sense one edge early");
    step(1);
    check(sns_rst_n, 1'b1, "R5 sense release edge");

    // R7: power-fail latency
    pf_ok = 1'b0;
    step(1);
    check(pf_good, 1'b1, "R7 pwr after one edge");
    step(1);
    check(pf_good, 1'b0, "R7 pwr after two edges");
    pf_ok = 1'b1;
    step(2);
    check(pf_good, 1'b1, "R7 pwr rise after two edges");

    // R6: one-cycle fault pulse restarts the count
    sup_ok = 1'b0;
    step(5);
    sup_ok = 1'b1;
    step(SUP_D - 2);
    sup_ok = 1'b0;
    step(1);
    sup_ok = 1'b1;
    step(SUP_D + 1);
    check(sup_rst_n, 1'b0, "R6 supply held after restart");
    step(1);
    check(sup_rst_n, 1'b1, "R6 supply release after restart");
    check(sns_rst_n, 1'b1, "R2 sense untouched by supply pulse");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule